// File: doc/BRIEF.md
# ADC Channel-List Acquisition Controller

This block is the register-mapped front end of a 16-channel, 12-bit sampling converter. Software loads a queue of 8-bit channel descriptors and picks a trigger mode in a control register. In software-trigger mode, a read of the start address launches one conversion. The block then raises a request toward the converter and presents the descriptor at the head of the queue. When the converter answers with a done strobe and an offset-binary code, the block turns the code into two's complement, stores it in a result FIFO, and moves the queue head on. The head wraps round the loaded entries, so repeated starts walk the list in a cycle.

A status word reports the busy state, the FIFO flags and five sticky pending-interrupt flags. The half-full flag comes from inside the block. The other four come from event inputs fed by timers and triggers that live outside it. Any write to the status address clears every pending flag. The interrupt line is the OR of the pending flags that are individually enabled, gated by a global enable.

Byte offsets: 0x00 is written as control word 1 and read as the conversion start. 0x02 is control word 2, write only. 0x04 is read as status, and any write there clears the pending flags. 0x10 is read as a pop of the result FIFO and written as a push onto the channel list. Any other read returns zero.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control word 1 bits 1:0 set the mode: 0 off, 1 software, 2 scan, 3 external. A start read (read of 0x00) launches a conversion only in mode 1. In any other mode, conv_req stays low.
- R2: A start read that is accepted raises conv_req on the next clock. conv_cfg carries the channel-list head entry and stays stable until conv_done is sampled high. A list entry holds the channel in bits 3:0, the gain in bits 5:4, unipolar in bit 6 and differential in bit 7.
- R3: Each completed conversion moves the head to the next loaded entry, wrapping from the last loaded entry back to the first.
- R4: The stored result is conv_data with bit 11 inverted. A read of 0x10 returns it in bits 11:0 in FIFO order, and returns zero when the FIFO is empty.
- R5: A start read while a conversion is busy is ignored. It produces no extra request and no extra result. A start read with an empty channel list is also ignored.
- R6: Status bit 1 is set while the channel list holds 16 entries. A write to 0x10 while the list is full is dropped.
- R7: Control word 2 bit 9 enables the channel list and bit 10 enables the result FIFO. While either bit is 0, the matching FIFO is held empty.
- R8: Status bit 2 means the result FIFO is empty, bit 3 that it holds at least 8 entries, and bit 4 that it holds 16. A result that arrives while the FIFO is full is dropped, and the older contents stay as they were.
- R9: Status bit 8 is set when the result FIFO reaches half-full. irq is the OR over bits 12:8 of (status AND control word 1 bits 12:8), ANDed with control word 1 bit 15.
- R10: evt_in[3:0] set the sticky status bits 12:9 (external, list-ready, counter A, counter B). Any write to 0x04 clears status bits 12:8.
- R11: Status bit 0 is 1 while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| conv_req | output | 1 | Conversion request, held until done |
| conv_cfg | output | 8 | Descriptor of the channel being converted |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Offset-binary converter code |
| evt_in | input | 4 | External event pulses for pending bits 12:9 |
| irq | output | 1 | Interrupt request |

## Verification
A table of four distinct descriptors and six converter codes runs through back-to-back conversions. The codes cover zero, both sides of the mid-scale boundary and full scale. Together they separate a correct bit-11 inversion from a full negation or no conversion at all, and a cyclic head from one that stops or restarts. Directed runs then fill the result FIFO past its half and full points, so a dropped push can be told apart from an overwrite. They also issue a start while busy and with an empty list, flush each FIFO through its enable bit, and toggle individual and global interrupt enables against pending flags set both inside and outside the block.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam logic [4:0] OFS_CTRL1 = 5'h00;
   localparam logic [4:0] OFS_CTRL2 = 5'h02;
   localparam logic [4:0] OFS_STAT  = 5'h04;
   localparam logic [4:0] OFS_FIFO  = 5'h10;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_SOFT = 2'd1,
      MODE_SCAN = 2'd2,
      MODE_EXT  = 2'd3
   } adc_mode_e;

   typedef struct packed {
      logic       diff;
      logic       unipolar;
      logic [1:0] gain;
      logic [3:0] chan;
   } list_entry_t;
endpackage

// File: rtl/adc_chan_list.sv
module adc_chan_list
   import adc_seq_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        push,
   input  list_entry_t din,
   input  logic        advance,
   output list_entry_t head_entry,
   output logic        empty,
   output logic        full
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("adc_chan_list: DEPTH must be a power of two >= 2");
      end
   endgenerate

   list_entry_t       mem [DEPTH];
   logic [CW-1:0]     count;
   logic [PW-1:0]     head;

   assign empty      = (count == '0);
   assign full       = (count == CW'(DEPTH));
   assign head_entry = mem[head];

   always_ff @(posedge clk) begin
      if (en && push && !full) mem[count[PW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         head  <= '0;
      end else if (!en) begin
         count <= '0;
         head  <= '0;
      end else begin
         if (push && !full) count <= count + 1'b1;
         if (advance && !empty)
            head <= ({1'b0, head} == count - 1'b1) ? '0 : head + 1'b1;
      end
   end

   AST_LIST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> empty) else $error("list not flushed");          // R7
   AST_LIST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      full && push |=> full) else $error("list lost entries");  // R6
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              half,
   output logic              full
);
   localparam int unsigned PW   = $clog2(DEPTH);
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam int unsigned HALF = DEPTH / 2;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("adc_result_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     count;
   logic              do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign half    = (count >= CW'(HALF));
   assign dout    = mem[rd_ptr];
   assign do_push = en && push && !full;
   assign do_pop  = en && pop && !empty;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (!en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)) else $error("result fifo overflow");  // R8
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      en && full && !pop |=> full) else $error("full dropped");  // R8
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl #(
   parameter int unsigned NSRC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic            clr,
   input  logic [NSRC-1:0] mask,
   input  logic            gie,
   output logic [NSRC-1:0] pend,
   output logic            irq
);
   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_pend
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pend[i] <= 1'b0;
            else if (clr)   pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
         end
      end
   endgenerate

   assign irq = gie && |(pend & mask);

   AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq) else $error("irq without global enable");  // R9
   AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> pend == '0) else $error("pending not cleared");   // R10
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned LIST_DEPTH = 16,
   parameter int unsigned RES_DEPTH  = 16,
   parameter int unsigned SAMPLE_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [4:0]          bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [15:0]         bus_wdata,
   output logic [15:0]         bus_rdata,
   output logic                conv_req,
   output logic [7:0]          conv_cfg,
   input  logic                conv_done,
   input  logic [SAMPLE_W-1:0] conv_data,
   input  logic [3:0]          evt_in,
   output logic                irq
);
   localparam int unsigned NSRC = 5;

   generate
      if (SAMPLE_W > 16 || SAMPLE_W < 2) begin : g_bad_width
         $error("adc_seq_ctrl: SAMPLE_W must fit the 16-bit bus");
      end
   endgenerate

   logic [15:0]         ctrl1;
   logic [1:0]          ctrl2_en;
   logic                busy;
   list_entry_t         cfg_q, head_entry;
   logic                list_empty, list_full;
   logic                res_empty, res_half, res_full, half_q;
   logic [SAMPLE_W-1:0] res_dout;
   logic [NSRC-1:0]     pend;
   adc_mode_e           mode;
   logic                sel_c1, sel_c2, sel_st, sel_ff;
   logic                start, finish;

   assign sel_c1 = (bus_addr == OFS_CTRL1);
   assign sel_c2 = (bus_addr == OFS_CTRL2);
   assign sel_st = (bus_addr == OFS_STAT);
   assign sel_ff = (bus_addr == OFS_FIFO);
   assign mode   = adc_mode_e'(ctrl1[1:0]);
   assign start  = bus_rd && sel_c1 && (mode == MODE_SOFT) && !busy && !list_empty;
   assign finish = busy && conv_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl1    <= '0;
         ctrl2_en <= '0;
         busy     <= 1'b0;
         cfg_q    <= '0;
         half_q   <= 1'b0;
      end else begin
         half_q <= res_half;
         if (bus_wr && sel_c1) ctrl1    <= bus_wdata;
         if (bus_wr && sel_c2) ctrl2_en <= bus_wdata[10:9];
         if (start) begin
            busy  <= 1'b1;
            cfg_q <= head_entry;
         end else if (finish) begin
            busy  <= 1'b0;
         end
      end
   end

   adc_chan_list #(.DEPTH(LIST_DEPTH)) u_list (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl2_en[0]),
      .push       (bus_wr && sel_ff),
      .din        (list_entry_t'(bus_wdata[7:0])),
      .advance    (finish),
      .head_entry (head_entry),
      .empty      (list_empty),
      .full       (list_full)
   );

   adc_result_fifo #(.DEPTH(RES_DEPTH), .DATA_W(SAMPLE_W)) u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl2_en[1]),
      .push  (finish),
      .din   (conv_data ^ (SAMPLE_W'(1) << (SAMPLE_W - 1))),
      .pop   (bus_rd && sel_ff),
      .dout  (res_dout),
      .empty (res_empty),
      .half  (res_half),
      .full  (res_full)
   );

   adc_irq_ctrl #(.NSRC(NSRC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   ({evt_in, res_half && !half_q}),
      .clr   (bus_wr && sel_st),
      .mask  (ctrl1[12:8]),
      .gie   (ctrl1[15]),
      .pend  (pend),
      .irq   (irq)
   );

   assign conv_req = busy;
   assign conv_cfg = cfg_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_st)
            bus_rdata = {3'b000, pend, 3'b000, res_full, res_half, res_empty,
                         list_full, busy};
         else if (sel_ff && !res_empty)
            bus_rdata = 16'(res_dout);
      end
   end

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_done |=> $stable(conv_cfg) && conv_req)
      else $error("descriptor changed mid-conversion");           // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_done && bus_rd && sel_c1 |=> $stable(conv_cfg))
      else $error("start accepted while busy");                   // R5
   AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && mode != MODE_SOFT |=> !conv_req)
      else $error("conversion outside software mode");            // R1
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        conv_req;
   logic [7:0]  conv_cfg;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;
   logic [3:0]  evt_in = '0;
   logic        irq;

   int tests = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   adc_seq_ctrl uut (.*);

   localparam logic [7:0]  ENT   [4] = '{8'h05, 8'h3A, 8'hC1, 8'h7F};
   localparam logic [11:0] CODES [6] = '{12'h000, 12'h7FF, 12'h800,
                                         12'hFFF, 12'h123, 12'hABC};

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bwr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #0.5 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic finish_conv(input logic [11:0] code);
      @(negedge clk); @(negedge clk);
      conv_done = 1'b1; conv_data = code;
      @(negedge clk); conv_done = 1'b0;
   endtask

   task automatic convert(input logic [11:0] code);
      logic [15:0] d;
      brd(5'h00, d);
      finish_conv(code);
   endtask

   task automatic pulse_evt(input logic [3:0] v);
      @(negedge clk); evt_in = v;
      @(negedge clk); evt_in = '0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      brd(5'h04, d); chk("R8 reset status", d, 16'h0004);
      chk("R9 reset irq", {15'd0, irq}, 16'd0);
      chk("R2 reset req", {15'd0, conv_req}, 16'd0);

      bwr(5'h02, 16'h0600);
      for (int i = 0; i < 4; i++) bwr(5'h10, {8'h00, ENT[i]});
      // R1: mode off ignores start
      brd(5'h00, d); @(negedge clk);
      chk("R1 start ignored when off", {15'd0, conv_req}, 16'd0);
      bwr(5'h00, 16'h0002);
      brd(5'h00, d); @(negedge clk);
      chk("R1 start ignored in scan mode", {15'd0, conv_req}, 16'd0);

      // table walk: R2 R3 R4
      bwr(5'h00, 16'h0001);
      for (int i = 0; i < 6; i++) begin
         brd(5'h00, d);
         chk("R2 request raised", {15'd0, conv_req}, 16'd1);
         chk("R3 cyclic descriptor", {8'h00, conv_cfg}, {8'h00, ENT[i % 4]});
         finish_conv(CODES[i]);
         brd(5'h10, d);
         chk("R4 result conversion", d, {4'h0, CODES[i] ^ 12'h800});
      end
      brd(5'h10, d); chk("R4 empty read zero", d, 16'h0000);

      // R5 / R11: start while busy ignored
      brd(5'h00, d);
      brd(5'h04, d); chk("R11 busy flag", d & 16'h0001, 16'h0001);
      brd(5'h00, d);
      chk("R5 descriptor held", {8'h00, conv_cfg}, {8'h00, ENT[2]});
      finish_conv(12'h456);
      @(negedge clk);
      chk("R5 no extra request", {15'd0, conv_req}, 16'd0);
      brd(5'h10, d); chk("R5 single result", d, 16'h0C56);
      brd(5'h04, d); chk("R5 fifo empty after one", d & 16'h001D, 16'h0004);

      // R6 list full
      for (int i = 0; i < 12; i++) bwr(5'h10, 16'h0011);
      brd(5'h04, d); chk("R6 list full flag", d & 16'h0002, 16'h0002);
      bwr(5'h10, 16'h00EE);
      // R7 list flush
      bwr(5'h02, 16'h0400);
      brd(5'h04, d); chk("R7 list flushed", d & 16'h0002, 16'h0000);
      brd(5'h00, d); @(negedge clk);
      chk("R5 empty list start ignored", {15'd0, conv_req}, 16'd0);
      bwr(5'h02, 16'h0600);
      bwr(5'h10, 16'h002C);
      brd(5'h00, d);
      chk("R7 fresh head after flush", {8'h00, conv_cfg}, 16'h002C);
      finish_conv(12'h001);
      bwr(5'h02, 16'h0200);
      brd(5'h04, d); chk("R7 result flushed", d & 16'h0004, 16'h0004);
      bwr(5'h02, 16'h0600);

      // R8 R9 fill result FIFO
      bwr(5'h00, 16'h8101);
      for (int i = 0; i < 7; i++) convert(12'(i * 3));
      chk("R9 no irq below half", {15'd0, irq}, 16'd0);
      convert(12'd21);
      brd(5'h04, d); chk("R8 half flag and pending", d & 16'h0118, 16'h0108);
      chk("R9 irq at half", {15'd0, irq}, 16'd1);
      bwr(5'h04, 16'h0000);
      chk("R10 clear by write", {15'd0, irq}, 16'd0);
      for (int i = 8; i < 16; i++) convert(12'(i * 3));
      brd(5'h04, d); chk("R8 full flag", d & 16'h0010, 16'h0010);
      convert(12'h777);
      brd(5'h04, d); chk("R8 full kept after drop", d & 16'h0010, 16'h0010);
      for (int i = 0; i < 16; i++) begin
         brd(5'h10, d);
         if (i == 0 || i == 15)
            chk("R8 contents kept", d, {4'h0, 12'(i * 3) ^ 12'h800});
      end
      brd(5'h04, d); chk("R8 empty after drain", d & 16'h001C, 16'h0004);

      // R10 external events and gating
      bwr(5'h00, 16'h8001);
      pulse_evt(4'b0001);
      brd(5'h04, d); chk("R10 ext pending", d & 16'h1F00, 16'h0200);
      chk("R9 masked pending no irq", {15'd0, irq}, 16'd0);
      bwr(5'h00, 16'h8201);
      chk("R9 enabled pending irq", {15'd0, irq}, 16'd1);
      bwr(5'h00, 16'h0201);
      chk("R9 global gate", {15'd0, irq}, 16'd0);
      pulse_evt(4'b1010);
      brd(5'h04, d); chk("R10 counter bits", d & 16'h1F00, 16'h1600);
      bwr(5'h04, 16'hFFFF);
      brd(5'h04, d); chk("R10 all cleared", d & 16'h1F00, 16'h0000);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule